// File: doc/BRIEF.md
# Paged Byte DMA Engine

The engine moves single bytes between a byte-wide peripheral and a 32-bit memory bus on one channel. Software sets up the job through a small register file. It writes a byte count, a page tag, an offset inside the page and a direction, and it fills a 128-entry page-frame table. The memory address for each byte is the table entry picked by the tag, with the 12-bit offset placed below it. When the offset rolls over a 4 KiB boundary, the tag moves to the next table entry.

The peripheral holds a request line high while it wants service. For as long as the request is high and the engine is enabled, the engine moves one byte per step. Each moved byte decrements the count. When the count reaches zero, a status flag is raised and the engine stays enabled.

If the peripheral keeps requesting after the count is spent, the engine does not stall. In the peripheral-to-memory direction it keeps reading bytes and throws them away. In the memory-to-peripheral direction it keeps writing zero bytes. This goes on until the request drops.

Top module: `paged_dma`

## Requirements
- R1: After reset, the control, status, count, tag and offset registers all read zero, and no memory request or peripheral strobe is active.
- R2: Register addresses are as follows.
  - 0 is control: bit 0 enable, bit 1 direction (1 = peripheral to memory), bit 2 soft reset, which is write-only.
  - 1 is status: bit 0 terminal count.
  - 2 is the count, which keeps all 32 bits.
  - 3 is the tag, which keeps its low 7 bits.
  - 4 is the offset, which keeps its low 12 bits.
  - 5 is the table entry indexed by the tag, which keeps its low 15 bits.
  - Reads return each value zero-extended.
- R3: Every memory access uses address = table[tag] << 12 | offset.
- R4: A step starts only while the request is high and enable is set. In the peripheral-to-memory direction, the read strobe is asserted in the same cycle the request is first seen high.
- R5: Peripheral to memory: the engine pulses the read strobe, and the byte on the peripheral data input is taken at that clock edge. Then the engine issues one memory write. That write has byte enable 1 << address[1:0], and the byte is replicated on all four lanes (lane k is bits 8k+7..8k).
- R6: Memory to peripheral: the engine issues one memory read and takes the byte from lane address[1:0]. It then pulses the write strobe with that byte on the peripheral data output.
- R7: Each moved byte adds one to the offset and subtracts one from the count. When the offset wraps from 0xFFF to 0, the tag increments modulo 128.
- R8: A memory request stays asserted, with a stable address and direction, until the cycle in which the acknowledge is high.
- R9: When the count reaches zero, status bit 0 becomes 1, and control bit 0 stays 1.
- R10: With the count at zero and the request high, the engine does one of two things every cycle:
  - peripheral to memory: it pulses the read strobe and makes no memory access;
  - memory to peripheral: it pulses the write strobe with data 0x00.
- R11: Writing control with bit 2 set does the following:
  - clears enable, direction and the terminal-count flag;
  - drops any memory request in the next cycle;
  - leaves count, tag, offset and the table unchanged.
- R12: Writing the count register clears the terminal-count flag.
- R13: At most one of memory request, peripheral read strobe and peripheral write strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| perReq | input | 1 | Peripheral service request |
| perRdStrobe | output | 1 | Take one byte from the peripheral this cycle |
| perRdata | input | 8 | Byte from the peripheral |
| perWrStrobe | output | 1 | Give one byte to the peripheral this cycle |
| perWdata | output | 8 | Byte to the peripheral |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 27 | Memory byte address |
| memBe | output | 4 | Memory byte enables |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory access completes this cycle |

## Verification
Several properties are checked on every cycle:
- the one-hot relation between memory request and peripheral strobes;
- holding a request and its address until acknowledge;
- single-lane byte enables;
- zero data while padding;
- the count and tag stepping by exactly one;
- the terminal flag rising only at zero count, with enable kept.

Other behaviours need whole scenarios from the bench:
- the address translation and the order of data bytes across a page wrap;
- draining and padding for the right number of cycles;
- masking on register readback;
- a soft reset that abandons a pending access while the pointers keep their values.

// File: rtl/paged_dma_pkg.sv
package paged_dma_pkg;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_STAT  = 3'd1;
  localparam logic [2:0] REG_COUNT = 3'd2;
  localparam logic [2:0] REG_TAG   = 3'd3;
  localparam logic [2:0] REG_OFFS  = 3'd4;
  localparam logic [2:0] REG_MAP   = 3'd5;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_DIR  = 1;
  localparam int CTRL_SRST = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_PUT  = 2'd2
  } dmaState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic grabPer;
    logic grabMem;
    logic advance;
  } dmaStrobe_t;

endpackage

// File: rtl/paged_dma_ctrl.sv
module paged_dma_ctrl
  import paged_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       perReq,
  input  logic       memAck,
  input  logic       enable,
  input  logic       dirToMem,
  input  logic       countZero,
  input  logic       softRst,
  output logic       perRdStrobe,
  output logic       perWrStrobe,
  output logic       memReq,
  output logic       memWe,
  output dmaStrobe_t strobe
);

  dmaState_e state, stateNext;
  logic xferToMem, xferToMemNext;
  logic go;

  assign go = perReq && enable && !softRst;

  always_comb begin
    stateNext     = state;
    xferToMemNext = xferToMem;
    perRdStrobe   = 1'b0;
    perWrStrobe   = 1'b0;
    memReq        = 1'b0;
    memWe         = 1'b0;
    strobe        = '0;
    case (state)
      ST_IDLE: begin
        if (go) begin
          if (countZero) begin
            // count spent: drain or pad the peripheral
            perRdStrobe = dirToMem;
            perWrStrobe = !dirToMem;
          end else begin
            xferToMemNext = dirToMem;
            stateNext     = ST_MEM;
            if (dirToMem) begin
              perRdStrobe    = 1'b1;
              strobe.grabPer = 1'b1;
            end
          end
        end
      end
      ST_MEM: begin
        memReq = 1'b1;
        memWe  = xferToMem;
        if (memAck) begin
          if (xferToMem) begin
            strobe.advance = 1'b1;
            stateNext      = ST_IDLE;
          end else begin
            strobe.grabMem = 1'b1;
            stateNext      = ST_PUT;
          end
        end
      end
      ST_PUT: begin
        perWrStrobe    = 1'b1;
        strobe.advance = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
    if (softRst) begin
      stateNext = ST_IDLE;
      strobe    = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      xferToMem <= 1'b0;
    end else begin
      state     <= stateNext;
      xferToMem <= xferToMemNext;
    end
  end

  assert_one_action_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memReq, perRdStrobe, perWrStrobe}));

  assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !softRst |=> memReq && (memWe == $past(memWe)));

  assert_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    perRdStrobe |-> perReq && enable);

  assert_soft_stop_R11: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !memReq && !perRdStrobe && !perWrStrobe);

endmodule

// File: rtl/paged_dma_path.sv
module paged_dma_path
  import paged_dma_pkg::*;
#(
  parameter  int TAG_W  = 7,
  parameter  int PAGE_W = 15,
  parameter  int OFF_W  = 12,
  parameter  int CNT_W  = 32,
  parameter  int DATA_W = 32,
  localparam int ADDR_W = PAGE_W + OFF_W,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int DEPTH  = 1 << TAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  dmaStrobe_t        strobe,
  input  logic [7:0]        perRdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              enable,
  output logic              dirToMem,
  output logic              countZero,
  output logic              softRst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic [7:0]        perWdata
);

  logic              tcZero;
  logic [CNT_W-1:0]  count;
  logic [TAG_W-1:0]  tag;
  logic [OFF_W-1:0]  offs;
  logic [7:0]        dataByte;
  logic [PAGE_W-1:0] mapTab [DEPTH];
  logic [LANE_W-1:0] lane;
  logic wrCtrl, wrCount, wrTag, wrOffs, wrMap, pageEnd;

  assign wrCtrl   = regWe && (regAddr == REG_CTRL);
  assign wrCount  = regWe && (regAddr == REG_COUNT);
  assign wrTag    = regWe && (regAddr == REG_TAG);
  assign wrOffs   = regWe && (regAddr == REG_OFFS);
  assign wrMap    = regWe && (regAddr == REG_MAP);
  assign softRst  = wrCtrl && regWdata[CTRL_SRST];
  assign countZero = (count == '0);
  assign pageEnd  = (offs == '1);
  assign lane     = offs[LANE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable   <= 1'b0;
      dirToMem <= 1'b0;
      tcZero   <= 1'b0;
      count    <= '0;
      tag      <= '0;
      offs     <= '0;
      dataByte <= '0;
    end else begin
      if (softRst) begin
        enable   <= 1'b0;
        dirToMem <= 1'b0;
      end else if (wrCtrl) begin
        enable   <= regWdata[CTRL_EN];
        dirToMem <= regWdata[CTRL_DIR];
      end

      if (softRst || wrCount) tcZero <= 1'b0;
      else if (strobe.advance && count == CNT_W'(1)) tcZero <= 1'b1;

      if (wrCount) count <= regWdata[CNT_W-1:0];
      else if (strobe.advance && !countZero) count <= count - 1'b1;

      if (wrTag) tag <= regWdata[TAG_W-1:0];
      else if (strobe.advance && pageEnd) tag <= tag + 1'b1;

      if (wrOffs) offs <= regWdata[OFF_W-1:0];
      else if (strobe.advance) offs <= offs + 1'b1;

      if (strobe.grabPer) dataByte <= perRdata;
      else if (strobe.grabMem) dataByte <= memRdata[lane*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (wrMap) mapTab[tag] <= regWdata[PAGE_W-1:0];
  end

  assign memAddr  = {mapTab[tag], offs};
  assign memBe    = LANES'(1) << lane;
  assign memWdata = {LANES{dataByte}};
  assign perWdata = countZero ? 8'h00 : dataByte;

  always_comb begin
    case (regAddr)
      REG_CTRL:  regRdata = 32'({dirToMem, enable});
      REG_STAT:  regRdata = 32'(tcZero);
      REG_COUNT: regRdata = 32'(count);
      REG_TAG:   regRdata = 32'(tag);
      REG_OFFS:  regRdata = 32'(offs);
      REG_MAP:   regRdata = 32'(mapTab[tag]);
      default:   regRdata = '0;
    endcase
  end

  assert_tc_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tcZero) |-> countZero);

  assert_keep_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !regWe |=> enable);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !countZero && !regWe |=> count == $past(count) - 1'b1);

  assert_tag_carry_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && pageEnd && !regWe |=> (offs == '0) && (tag == $past(tag) + 1'b1));

endmodule

// File: rtl/paged_dma.sv
module paged_dma
  import paged_dma_pkg::*;
#(
  parameter  int TAG_W  = 7,
  parameter  int PAGE_W = 15,
  parameter  int OFF_W  = 12,
  parameter  int CNT_W  = 32,
  parameter  int DATA_W = 32,
  localparam int ADDR_W = PAGE_W + OFF_W,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              perReq,
  output logic              perRdStrobe,
  input  logic [7:0]        perRdata,
  output logic              perWrStrobe,
  output logic [7:0]        perWdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memBe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);

  dmaStrobe_t strobe;
  logic enable, dirToMem, countZero, softRst;

  paged_dma_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .perReq     (perReq),
    .memAck     (memAck),
    .enable     (enable),
    .dirToMem   (dirToMem),
    .countZero  (countZero),
    .softRst    (softRst),
    .perRdStrobe(perRdStrobe),
    .perWrStrobe(perWrStrobe),
    .memReq     (memReq),
    .memWe      (memWe),
    .strobe     (strobe)
  );

  paged_dma_path #(
    .TAG_W (TAG_W),
    .PAGE_W(PAGE_W),
    .OFF_W (OFF_W),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .strobe   (strobe),
    .perRdata (perRdata),
    .memRdata (memRdata),
    .enable   (enable),
    .dirToMem (dirToMem),
    .countZero(countZero),
    .softRst  (softRst),
    .memAddr  (memAddr),
    .memBe    (memBe),
    .memWdata (memWdata),
    .perWdata (perWdata)
  );

  assert_single_lane_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> $onehot(memBe));

  assert_pad_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    perWrStrobe && countZero |-> perWdata == 8'h00);

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !regWe |=> $stable(memAddr));

endmodule

// File: tb/test_paged_dma.sv
module test_paged_dma;
  localparam int PAGE_W = 15;
  localparam int ADDR_W = 27;
  localparam int LANES  = 4;
  localparam int WATCH  = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic              regWe = 1'b0;
  logic [2:0]        regAddr = '0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic              perReq = 1'b0;
  logic              perRdStrobe, perWrStrobe;
  logic [7:0]        perRdata = '0;
  logic [7:0]        perWdata;
  logic              memReq, memWe;
  logic              memAck = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [LANES-1:0]  memBe;
  logic [31:0]       memWdata;
  logic [31:0]       memRdata = '0;

  paged_dma i_paged_dma (.*);

  int total = 0, bad = 0, cycles = 0;
  bit timedOut = 0;
  bit pendWe = 0, reqLvl = 0, noAck = 0, rdTaken = 0, prevWait = 0, lastMemReq = 0;
  logic [2:0]  pendAddr = '0;
  logic [31:0] pendData = '0, lastRd = '0;
  logic [ADDR_W-1:0] prevAddr = '0;
  int rdIdx = 0, holdViol = 0, multiViol = 0;
  int nWr = 0, nRdMem = 0, nPerRd = 0, nPerWr = 0;
  logic [ADDR_W-1:0] wrAddr [256];
  logic [LANES-1:0]  wrBe   [256];
  logic [31:0]       wrData [256];
  logic [ADDR_W-1:0] rdAddr [256];
  logic [7:0]        perWrVal [256];
  logic [PAGE_W-1:0] benchMap [128];

  function automatic logic [7:0] perPat(int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] byteAt(logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] wordAt(logic [ADDR_W-1:0] a);
    logic [31:0] w;
    for (int j = 0; j < LANES; j++) w[j*8 +: 8] = byteAt({a[ADDR_W-1:2], 2'(j)});
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] expAddr(int t0, int o0, int i);
    int tot = o0 + i;
    int off = tot % 4096;
    int t = (t0 + tot / 4096) % 128;
    return {benchMap[t], 12'(off)};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: drive after falling edge, sample and respond 1 ns later
  task automatic cyc();
    @(negedge clk);
    cycles++;
    if (cycles > WATCH) timedOut = 1;
    regWe = pendWe; regAddr = pendAddr; regWdata = pendData; pendWe = 0;
    perReq = reqLvl;
    if (rdTaken) rdIdx++;
    perRdata = perPat(rdIdx);
    memAck = 1'b0;
    #1;
    memRdata = wordAt(memAddr);
    rdTaken = perRdStrobe;
    if (int'(memReq) + int'(perRdStrobe) + int'(perWrStrobe) > 1) multiViol++;
    if (perRdStrobe) nPerRd++;
    if (perWrStrobe) begin
      if (nPerWr < 256) perWrVal[nPerWr] = perWdata;
      nPerWr++;
    end
    lastMemReq = memReq;
    if (memReq) begin
      if (prevWait && memAddr != prevAddr) holdViol++;
      if (!noAck && ($urandom % 3) != 0) begin
        memAck = 1'b1;
        if (memWe) begin
          if (nWr < 256) begin
            wrAddr[nWr] = memAddr; wrBe[nWr] = memBe; wrData[nWr] = memWdata;
          end
          nWr++;
        end else begin
          if (nRdMem < 256) rdAddr[nRdMem] = memAddr;
          nRdMem++;
        end
      end
      prevWait = !memAck;
      prevAddr = memAddr;
    end else prevWait = 0;
    lastRd = regRdata;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    pendWe = 1; pendAddr = a; pendData = d;
    cyc();
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    pendAddr = a;
    cyc();
    d = lastRd;
  endtask

  task automatic clearLogs();
    nWr = 0; nRdMem = 0; nPerRd = 0; nPerWr = 0;
  endtask

  task automatic runXfer(bit toMem, int n, int t0, int o0, int pad);
    logic [31:0] v;
    int base, g, off;
    logic [ADDR_W-1:0] ea;
    wr(3'd2, 32'(n));
    wr(3'd3, 32'(t0));
    wr(3'd4, 32'(o0));
    wr(3'd0, toMem ? 32'd3 : 32'd1);
    clearLogs();
    base = rdIdx;
    reqLvl = 1;
    g = 0;
    do begin
      cyc();
      if (g == 0 && toMem) chk(nPerRd == 1, "R4", "read strobe in first request cycle", nPerRd, 1);
      g++;
    end while (((toMem ? nWr : nPerWr) < n) && g < 4000 && !timedOut);
    chk(g < 4000, "R4", "transfer finished", g, n);
    repeat (pad) cyc();
    reqLvl = 0;
    cyc();
    if (toMem) begin
      chk(nWr == n, "R5", "memory write count", nWr, n);
      for (int i = 0; i < n && i < nWr; i++) begin
        ea = expAddr(t0, o0, i);
        chk(wrAddr[i] == ea, "R3", "write address", wrAddr[i], ea);
        chk(wrBe[i] == (4'b1 << ea[1:0]), "R5", "byte enable", wrBe[i], 4'b1 << ea[1:0]);
        chk(wrData[i][ea[1:0]*8 +: 8] == perPat(base + i), "R5", "written byte",
            wrData[i][ea[1:0]*8 +: 8], perPat(base + i));
      end
      chk(nPerRd == n + pad, "R10", "drain read strobes", nPerRd, n + pad);
    end else begin
      chk(nRdMem == n, "R6", "memory read count", nRdMem, n);
      for (int i = 0; i < n && i < nRdMem; i++) begin
        ea = expAddr(t0, o0, i);
        chk(rdAddr[i] == ea, "R3", "read address", rdAddr[i], ea);
        chk(perWrVal[i] == byteAt(ea), "R6", "byte to peripheral", perWrVal[i], byteAt(ea));
      end
      chk(nPerWr == n + pad, "R10", "pad write strobes", nPerWr, n + pad);
      for (int i = n; i < n + pad && i < nPerWr; i++)
        chk(perWrVal[i] == 8'h00, "R10", "pad byte", perWrVal[i], 0);
    end
    rd(3'd1, v); chk(v == 32'd1, "R9", "terminal count flag", v, 1);
    rd(3'd0, v); chk(v[0] == 1'b1, "R9", "enable kept", v[0], 1);
    rd(3'd2, v); chk(v == 32'd0, "R7", "count at end", v, 0);
    off = (o0 + n) % 4096;
    rd(3'd4, v); chk(v == 32'(off), "R7", "offset at end", v, off);
    rd(3'd3, v); chk(v == 32'((t0 + (o0 + n) / 4096) % 128), "R7", "tag at end", v,
                     (t0 + (o0 + n) / 4096) % 128);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk(v == 32'd0, "R1", "register after reset", v, 0);
    end
    chk(!lastMemReq && !perRdStrobe && !perWrStrobe, "R1", "idle after reset", lastMemReq, 0);

    wr(3'd0, 32'd3); rd(3'd0, v); chk(v == 32'd3, "R2", "control readback", v, 3);
    wr(3'd0, 32'd0);
    wr(3'd3, 32'hFFFF_FF85); rd(3'd3, v); chk(v == 32'h05, "R2", "tag mask", v, 5);
    wr(3'd4, 32'hABCD_E345); rd(3'd4, v); chk(v == 32'h345, "R2", "offset mask", v, 32'h345);
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); chk(v == 32'h7FFF, "R2", "map entry mask", v, 32'h7FFF);
    wr(3'd2, 32'hDEAD_BEEF); rd(3'd2, v); chk(v == 32'hDEAD_BEEF, "R2", "count readback", v, 32'hDEAD_BEEF);

    for (int t = 0; t < 128; t++) begin
      benchMap[t] = 15'($urandom);
      wr(3'd3, 32'(t));
      wr(3'd5, {17'($urandom), benchMap[t]});
    end

    runXfer(1, 6, 10, 0, 3);
    runXfer(0, 5, 127, 4094, 4);

    wr(3'd0, 32'd4);
    rd(3'd1, v); chk(v == 32'd0, "R11", "soft reset clears flag", v, 0);
    rd(3'd0, v); chk(v == 32'd0, "R11", "soft reset clears control", v, 0);

    runXfer(1, 4, 3, 4093, 0);
    wr(3'd2, 32'd7);
    rd(3'd1, v); chk(v == 32'd0, "R12", "count write clears flag", v, 0);

    wr(3'd2, 32'd5); wr(3'd0, 32'd2);
    clearLogs();
    reqLvl = 1; repeat (8) cyc(); reqLvl = 0; cyc();
    chk(nPerRd == 0 && nPerWr == 0 && nWr == 0 && nRdMem == 0, "R4", "no activity while disabled",
        nPerRd + nPerWr + nWr + nRdMem, 0);
    rd(3'd2, v); chk(v == 32'd5, "R4", "count untouched while disabled", v, 5);

    wr(3'd2, 32'd4); wr(3'd3, 32'd2); wr(3'd4, 32'd0); wr(3'd0, 32'd1);
    clearLogs();
    noAck = 1; reqLvl = 1;
    repeat (3) cyc();
    chk(lastMemReq == 1'b1, "R8", "request held without acknowledge", lastMemReq, 1);
    wr(3'd0, 32'd4);
    cyc();
    chk(lastMemReq == 1'b0, "R11", "request dropped after soft reset", lastMemReq, 0);
    chk(nPerWr == 0, "R11", "no peripheral write after soft reset", nPerWr, 0);
    reqLvl = 0; noAck = 0;
    rd(3'd2, v); chk(v == 32'd4, "R11", "count kept", v, 4);
    rd(3'd3, v); chk(v == 32'd2, "R11", "tag kept", v, 2);

    for (int r = 0; r < 10; r++) begin
      bit dirBit;
      int n, t0, o0, pad;
      dirBit = 1'($urandom % 2);
      n = 1 + int'($urandom % 20);
      t0 = int'($urandom % 128);
      o0 = ($urandom % 2) != 0 ? 4095 - int'($urandom % 8) : int'($urandom % 4096);
      pad = int'($urandom % 5);
      runXfer(dirBit, n, t0, o0, pad);
    end

    chk(holdViol == 0, "R8", "address changed while waiting", holdViol, 0);
    chk(multiViol == 0, "R13", "overlapping actions", multiViol, 0);
    chk(!timedOut, "watchdog", "run length", cycles, WATCH);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule